// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steps a small system through six graded power modes: active, idle, sleep, power-down sleep, extended power-down sleep and deep off. Each mode has its own set of clock enables (CPU clock, system clock) and domain enables (radio power, core power, always-on register logic, RAM retention, low-power oscillator). Software asks for a mode with a one-cycle command. Entry gates the clocks first and cuts power one cycle later. The system leaves a low-power mode when a wake timer runs out or when a GPIO event arrives. On the way out, power comes back first, the sequencer waits for a ready handshake from the regulators, and only then are the clocks released.

The wake timer is loaded from `wake_time` when a command is accepted. It counts down once per `lp_tick`, a one-cycle enable that stands in for an edge of the low-power clock. A wake record holds the cause of the last wake (timer and/or GPIO) and whether that wake came out of deep off. The record is reset only by `por_n`, so it survives the `rst_n` reset that follows a deep-off exit. That reset is requested through `reinit_req`.

FSM states: RUN (holding a mode, commands accepted), GATE (target clocks applied, power still on), LOW (target power applied, waiting for a wake), RESTORE (active power applied, waiting for `pwr_ready`). Transitions: RUN→GATE on an accepted command; GATE→LOW on the next cycle; LOW→RESTORE on a wake; RESTORE→RUN when `pwr_ready` is high.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `cur_mode` is 0 (active), every clock and domain enable is 1 and `reinit_req` is 0. `wake_cause` and `from_deepoff` are cleared only by `por_n`.
- R2: The `cmd_mode` encoding is 1 idle, 2 sleep, 3 power-down sleep, 4 extended power-down sleep, 5 deep off. A command with one of these codes is accepted only in RUN while active. Codes 0, 6 and 7 are ignored: the mode stays active.
- R3: Idle gates only the CPU clock. Sleep gates both clocks and keeps every power domain and the low-power oscillator on.
- R4: Power-down sleep turns off radio and core power and keeps always-on logic, RAM retention and the oscillator on. Extended power-down sleep also turns off the always-on logic and keeps only RAM retention and the oscillator.
- R5: Deep off turns off every domain. `lpo_en` stays 1 only when the command had `cmd_tmr_en` set.
- R6: At the edge that accepts a command, the clock enables take the target values while all power enables stay 1. The power enables take the target values at the next edge.
- R7: The timer counts down from `wake_time` only when enabled, on edges in LOW where `lp_tick` is 1. It wakes at the first LOW edge after it reaches zero. Without `lp_tick` it does not wake.
- R8: A GPIO event (`gpio_evt` high) in LOW wakes the block at that edge, in any mode.
- R9: On a wake, all power enables return to 1 at the waking edge while the clocks stay gated. The clocks are released only at an edge where `pwr_ready` is 1, and `cur_mode` then returns to 0.
- R10: A command is ignored while `gpio_evt` is high.
- R11: At a wake, `wake_cause` bit 0 records a timer expiry and bit 1 records a GPIO event. `from_deepoff` records whether the wake came out of deep off. The record is cleared when the next command is accepted and is kept through `rst_n`.
- R12: After a deep-off wake, `reinit_req` is 1 for exactly the one cycle that begins with the clock release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the sequencer and timer |
| por_n | input | 1 | Active-low power-on reset of the wake record |
| cmd_valid | input | 1 | Mode request strobe |
| cmd_mode | input | 3 | Requested mode code |
| cmd_tmr_en | input | 1 | Enable timer wake for the request |
| wake_time | input | 32 | Timer load value in low-power ticks |
| lp_tick | input | 1 | Low-power clock tick enable |
| gpio_evt | input | 1 | External GPIO wake event |
| pwr_ready | input | 1 | Regulators report restored power |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | System clock enable |
| radio_pwr_en | output | 1 | Radio domain power |
| core_pwr_en | output | 1 | Core domain power |
| aon_pwr_en | output | 1 | Always-on register logic power |
| ram_ret_en | output | 1 | RAM retention power |
| lpo_en | output | 1 | Low-power oscillator enable |
| cur_mode | output | 3 | Mode being entered or held |
| wake_cause | output | 2 | Bit 0 timer, bit 1 GPIO |
| from_deepoff | output | 1 | Last wake came from deep off |
| reinit_req | output | 1 | One-cycle full re-initialisation request |

## Verification
A corrupted FSM state or level register shows up at the enable ports at the next edge. The symptom is a clock enabled over an unpowered core, a broken retention grade (for example RAM off while the always-on logic is on), or clocks returning before `pwr_ready`. A timer that is loaded or decremented wrongly shows up as a wake that comes exactly one or more ticks off the expected edge. A bad wake record shows up as a zero cause or a missing deep-off flag in the same cycle as the wake.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        M_ACTIVE = 3'd0,
        M_IDLE   = 3'd1,
        M_SLEEP  = 3'd2,
        M_PDS    = 3'd3,
        M_EPDS   = 3'd4,
        M_DEEP   = 3'd5
    } pmode_e;

    typedef enum logic [1:0] {
        S_RUN,
        S_GATE,
        S_LOW,
        S_RESTORE
    } seq_e;

    typedef struct packed {
        logic cpu;
        logic sys;
    } clk_set_t;

    typedef struct packed {
        logic radio;
        logic core;
        logic aon;
        logic ram;
        logic lpo;
    } pwr_set_t;

    function automatic logic mode_ok(logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd5);
    endfunction

    function automatic clk_set_t clk_of(pmode_e m);
        clk_set_t c;
        c.cpu = (m == M_ACTIVE);
        c.sys = (m == M_ACTIVE) || (m == M_IDLE);
        return c;
    endfunction

    function automatic pwr_set_t pwr_of(pmode_e m, logic tmr);
        pwr_set_t p;
        p.radio = (m <= M_SLEEP);
        p.core  = (m <= M_SLEEP);
        p.aon   = (m <= M_PDS);
        p.ram   = (m <= M_EPDS);
        p.lpo   = (m != M_DEEP) || tmr;
        return p;
    endfunction

endpackage

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic             expired
);
    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && tick && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pwr_dom_decode.sv
module pwr_dom_decode
    import pwr_seq_pkg::*;
(
    input  pmode_e   clk_lvl,
    input  pmode_e   pwr_lvl,
    input  logic     tmr_en,
    output clk_set_t clks,
    output pwr_set_t pwrs
);
    always_comb begin
        clks = clk_of(clk_lvl);
        pwrs = pwr_of(pwr_lvl, tmr_en);
    end
endmodule

// File: rtl/pwr_wake_record.sv
module pwr_wake_record (
    input  logic       clk,
    input  logic       por_n,
    input  logic       clr,
    input  logic       cap,
    input  logic       cap_tmr,
    input  logic       cap_gpio,
    input  logic       cap_deep,
    output logic [1:0] cause,
    output logic       from_deep
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause     <= 2'b00;
            from_deep <= 1'b0;
        end else if (clr) begin
            cause     <= 2'b00;
            from_deep <= 1'b0;
        end else if (cap) begin
            cause     <= {cap_gpio, cap_tmr};
            from_deep <= cap_deep;
        end
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_mode,
    input  logic             cmd_tmr_en,
    input  logic [TMR_W-1:0] wake_time,
    input  logic             lp_tick,
    input  logic             gpio_evt,
    input  logic             pwr_ready,
    output logic             cpu_clk_en,
    output logic             sys_clk_en,
    output logic             radio_pwr_en,
    output logic             core_pwr_en,
    output logic             aon_pwr_en,
    output logic             ram_ret_en,
    output logic             lpo_en,
    output logic [2:0]       cur_mode,
    output logic [1:0]       wake_cause,
    output logic             from_deepoff,
    output logic             reinit_req
);
    seq_e     state, nxt_state;
    pmode_e   tgt, clk_lvl, pwr_lvl;
    logic     tmr_en, reinit_q, expired;
    logic     accept, wake, restore_done;
    clk_set_t clks;
    pwr_set_t pwrs;

    assign accept       = (state == S_RUN) && cmd_valid && !gpio_evt && mode_ok(cmd_mode);
    assign wake         = (state == S_LOW) && (gpio_evt || (tmr_en && expired));
    assign restore_done = (state == S_RESTORE) && pwr_ready;

    // next-state process
    always_comb begin
        nxt_state = state;
        unique case (state)
            S_RUN:     if (accept)    nxt_state = S_GATE;
            S_GATE:                   nxt_state = S_LOW;
            S_LOW:     if (wake)      nxt_state = S_RESTORE;
            S_RESTORE: if (pwr_ready) nxt_state = S_RUN;
            default:                  nxt_state = S_RUN;
        endcase
    end

    // state register and level registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_RUN;
            tgt      <= M_ACTIVE;
            clk_lvl  <= M_ACTIVE;
            pwr_lvl  <= M_ACTIVE;
            tmr_en   <= 1'b0;
            reinit_q <= 1'b0;
        end else begin
            state    <= nxt_state;
            reinit_q <= restore_done && (tgt == M_DEEP);
            if (accept) begin
                tgt     <= pmode_e'(cmd_mode);
                clk_lvl <= pmode_e'(cmd_mode);
                tmr_en  <= cmd_tmr_en;
            end
            if (state == S_GATE) pwr_lvl <= tgt;
            if (wake)            pwr_lvl <= M_ACTIVE;
            if (restore_done) begin
                clk_lvl <= M_ACTIVE;
                tgt     <= M_ACTIVE;
            end
        end
    end

    pwr_wake_timer #(.TMR_W(TMR_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wake_time),
        .run      (state == S_LOW),
        .tick     (lp_tick && tmr_en),
        .expired  (expired)
    );

    pwr_dom_decode decode_i (
        .clk_lvl (clk_lvl),
        .pwr_lvl (pwr_lvl),
        .tmr_en  (tmr_en),
        .clks    (clks),
        .pwrs    (pwrs)
    );

    pwr_wake_record record_i (
        .clk       (clk),
        .por_n     (por_n),
        .clr       (accept),
        .cap       (wake),
        .cap_tmr   (tmr_en && expired),
        .cap_gpio  (gpio_evt),
        .cap_deep  (tgt == M_DEEP),
        .cause     (wake_cause),
        .from_deep (from_deepoff)
    );

    // output process
    always_comb begin
        cpu_clk_en   = clks.cpu;
        sys_clk_en   = clks.sys;
        radio_pwr_en = pwrs.radio;
        core_pwr_en  = pwrs.core;
        aon_pwr_en   = pwrs.aon;
        ram_ret_en   = pwrs.ram;
        lpo_en       = pwrs.lpo;
        cur_mode     = tgt;
        reinit_req   = reinit_q;
    end
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_n,
    input logic       cmd_valid,
    input logic       gpio_evt,
    input logic       pwr_ready,
    input logic       cpu_clk_en,
    input logic       sys_clk_en,
    input logic       radio_pwr_en,
    input logic       core_pwr_en,
    input logic       aon_pwr_en,
    input logic       ram_ret_en,
    input logic       lpo_en,
    input logic [1:0] wake_cause,
    input logic       from_deepoff,
    input logic       reinit_req
);
    assert_clk_needs_core_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en || sys_clk_en) |-> core_pwr_en);

    assert_clk_after_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_clk_en) |-> $past(pwr_ready));

    assert_ignore_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && gpio_evt && cpu_clk_en) |=> cpu_clk_en);

    assert_grade_ram_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_ret_en |-> (!aon_pwr_en && !core_pwr_en && !radio_pwr_en));

    assert_grade_aon_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !aon_pwr_en |-> (!core_pwr_en && !radio_pwr_en));

    assert_lpo_off_deep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lpo_en |-> !ram_ret_en);

    assert_cause_set_R11: assert property (@(posedge clk) disable iff (!por_n)
        from_deepoff |-> (wake_cause != 2'b00));

    assert_reinit_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        reinit_req |=> !reinit_req);

    assert_reinit_deep_R12: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        reinit_req |-> (from_deepoff && cpu_clk_en));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_n        (por_n),
    .cmd_valid    (cmd_valid),
    .gpio_evt     (gpio_evt),
    .pwr_ready    (pwr_ready),
    .cpu_clk_en   (cpu_clk_en),
    .sys_clk_en   (sys_clk_en),
    .radio_pwr_en (radio_pwr_en),
    .core_pwr_en  (core_pwr_en),
    .aon_pwr_en   (aon_pwr_en),
    .ram_ret_en   (ram_ret_en),
    .lpo_en       (lpo_en),
    .wake_cause   (wake_cause),
    .from_deepoff (from_deepoff),
    .reinit_req   (reinit_req)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_tmr_en = 1'b0;
    logic [2:0]  cmd_mode = 3'd0;
    logic [31:0] wake_time = 32'd0;
    logic        lp_tick = 1'b0, gpio_evt = 1'b0, pwr_ready = 1'b0;
    logic        cpu_clk_en, sys_clk_en, radio_pwr_en, core_pwr_en;
    logic        aon_pwr_en, ram_ret_en, lpo_en, from_deepoff, reinit_req;
    logic [2:0]  cur_mode;
    logic [1:0]  wake_cause;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pwr_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .cmd_valid(cmd_valid),
        .cmd_mode(cmd_mode), .cmd_tmr_en(cmd_tmr_en), .wake_time(wake_time),
        .lp_tick(lp_tick), .gpio_evt(gpio_evt), .pwr_ready(pwr_ready),
        .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en),
        .radio_pwr_en(radio_pwr_en), .core_pwr_en(core_pwr_en),
        .aon_pwr_en(aon_pwr_en), .ram_ret_en(ram_ret_en), .lpo_en(lpo_en),
        .cur_mode(cur_mode), .wake_cause(wake_cause),
        .from_deepoff(from_deepoff), .reinit_req(reinit_req)
    );

    function automatic logic [1:0] clk_v();
        return {cpu_clk_en, sys_clk_en};
    endfunction
    function automatic logic [4:0] pwr_v();
        return {radio_pwr_en, core_pwr_en, aon_pwr_en, ram_ret_en, lpo_en};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R2 R6 R3 R4 R5: request a mode and check both entry steps
    task automatic enter(logic [2:0] m, logic te, logic [31:0] wt,
                         logic [1:0] exp_clk, logic [4:0] exp_pwr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = m; cmd_tmr_en = te; wake_time = wt;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R6", "clocks at accept", clk_v(), exp_clk);
        chk("R6", "power held at accept", pwr_v(), 5'b11111);
        chk("R2", "cur_mode", cur_mode, m);
        @(negedge clk);
        chk("R3/R4/R5", "power in mode", pwr_v(), exp_pwr);
    endtask

    // R9: called at the negedge right after the waking edge
    task automatic restore(logic [1:0] exp_clk);
        chk("R9", "power back at wake", pwr_v(), 5'b11111);
        chk("R9", "clocks held at wake", clk_v(), exp_clk);
        @(negedge clk);
        @(negedge clk);
        chk("R9", "clocks held without ready", clk_v(), exp_clk);
        pwr_ready = 1'b1;
        @(negedge clk);
        pwr_ready = 1'b0;
        chk("R9", "clocks released", clk_v(), 2'b11);
        chk("R9", "mode active", cur_mode, 3'd0);
    endtask

    task automatic gpio_pulse();
        @(negedge clk);
        gpio_evt = 1'b1;
        @(negedge clk);
        gpio_evt = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "clocks in reset", clk_v(), 2'b11);
        rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);
        chk("R1", "clocks", clk_v(), 2'b11);
        chk("R1", "power", pwr_v(), 5'b11111);
        chk("R1", "mode", cur_mode, 3'd0);
        chk("R1", "record", {from_deepoff, wake_cause, reinit_req}, 4'b0);
    endtask

    task automatic t_ignore();
        @(negedge clk);
        gpio_evt = 1'b1; cmd_valid = 1'b1; cmd_mode = 3'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        gpio_evt = 1'b0;
        chk("R10", "cmd during gpio ignored", {cur_mode, clk_v(), pwr_v()}, {3'd0, 2'b11, 5'b11111});
        for (int c = 6; c < 9; c++) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_mode = 3'(c);
            @(negedge clk);
            cmd_valid = 1'b0;
            @(negedge clk);
            chk("R2", "invalid code ignored", {cur_mode, clk_v(), pwr_v()}, {3'd0, 2'b11, 5'b11111});
        end
    endtask

    task automatic t_idle_gpio();
        enter(3'd1, 1'b0, 32'd0, 2'b01, 5'b11111);
        chk("R3", "idle sys clock", clk_v(), 2'b01);
        gpio_pulse();
        chk("R8", "gpio wake idle", wake_cause, 2'b10);
        restore(2'b01);
    endtask

    task automatic t_sleep_timer();
        lp_tick = 1'b1;
        enter(3'd2, 1'b1, 32'd3, 2'b00, 5'b11111);
        repeat (3) begin
            @(negedge clk);
            chk("R7", "not yet woken", clk_v(), 2'b00);
            chk("R7", "still sleeping", cur_mode, 3'd2);
        end
        @(negedge clk);
        chk("R7", "timer wake edge", wake_cause, 2'b01);
        chk("R11", "not deep", from_deepoff, 1'b0);
        restore(2'b00);
        lp_tick = 1'b0;
    endtask

    task automatic t_pds_notick();
        enter(3'd3, 1'b1, 32'd2, 2'b00, 5'b00111);
        repeat (10) @(negedge clk);
        chk("R7", "no tick no wake", pwr_v(), 5'b00111);
        lp_tick = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7", "two ticks still low", pwr_v(), 5'b00111);
        @(negedge clk);
        lp_tick = 1'b0;
        chk("R7", "wake after ticks", wake_cause, 2'b01);
        restore(2'b00);
    endtask

    task automatic t_epds_gpio();
        enter(3'd4, 1'b0, 32'd0, 2'b00, 5'b00011);
        gpio_pulse();
        chk("R8", "gpio wake epds", wake_cause, 2'b10);
        restore(2'b00);
    endtask

    task automatic t_deep_timer();
        lp_tick = 1'b1;
        enter(3'd5, 1'b1, 32'd1, 2'b00, 5'b00001);
        @(negedge clk);
        chk("R5", "deep timer lpo on", pwr_v(), 5'b00001);
        @(negedge clk);
        lp_tick = 1'b0;
        chk("R11", "deep timer cause", {from_deepoff, wake_cause}, 3'b101);
        restore(2'b00);
        chk("R12", "reinit pulse", reinit_req, 1'b1);
        @(negedge clk);
        chk("R12", "reinit one cycle", reinit_req, 1'b0);
    endtask

    task automatic t_deep_gpio();
        enter(3'd5, 1'b0, 32'd0, 2'b00, 5'b00000);
        repeat (4) @(negedge clk);
        chk("R5", "deep gpio only all off", pwr_v(), 5'b00000);
        gpio_pulse();
        chk("R11", "deep gpio cause", {from_deepoff, wake_cause}, 3'b110);
        restore(2'b00);
        chk("R12", "reinit pulse gpio", reinit_req, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "record kept through rst_n", {from_deepoff, wake_cause}, 3'b110);
        chk("R1", "mode after rst_n", cur_mode, 3'd0);
    endtask

    task automatic t_clear();
        enter(3'd1, 1'b0, 32'd0, 2'b01, 5'b11111);
        chk("R11", "record cleared on accept", {from_deepoff, wake_cause}, 3'b000);
        gpio_pulse();
        restore(2'b01);
    endtask

    initial begin
        t_reset();
        t_ignore();
        t_idle_gpio();
        t_sleep_timer();
        t_pds_notick();
        t_epds_gpio();
        t_deep_timer();
        t_deep_gpio();
        t_clear();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule